// File: doc/BRIEF.md
# Raster Beam Position Counter with Irregular Dots

This block follows the scan position of a console video unit from its master clock. It splits master cycles into dots, dots into scanlines and scanlines into frames. The position is reported as a horizontal dot count and a vertical line count.

Dots are not all the same length. Two dots on a normal line take 6 master cycles instead of 4. Because of this, a 340-dot line lasts 1364 cycles. In non-interlaced output, every second frame has one line, the first vertical-blank line, that runs with no stretched dots, so it lasts only 1360 cycles. In interlaced output, every second frame gets one extra line at the end instead.

A field flag flips at each frame start. Blanking flags are decoded from the live position. A strobe input copies both counts into holding registers in a single edge, so they can be read as a consistent pair.

Top module: `beam_pos_counter`

## Requirements
- R1: A clock edge with `rst_n` low clears both counts, the field flag, the latched counts and the stored interlace mode to zero; after reset the position is dot 0 of line 0.
- R2: A normal dot lasts `MCYC_DOT` (4) master cycles. The dot count runs 0 to `DOTS_PER_LINE`-1 (339), then returns to 0 and the line count advances by one.
- R3: On every line except the short line of R5, dots `LONG_DOT_A` (323) and `LONG_DOT_B` (327) each last `MCYC_LONG` (6) master cycles, so the line lasts 1364 cycles.
- R4: With interlace off, a frame has `LINES_PER_FIELD` (262) lines. The field flag inverts on the edge where the line count returns to 0.
- R5: With interlace off and the field flag at 1, line `SHORT_LINE` (240) has no stretched dots and lasts 1360 cycles. With the field flag at 0 that line is normal.
- R6: With interlace on, a frame with the field flag at 1 has `LINES_PER_FIELD`+1 (263) lines, and a frame with the field flag at 0 has 262. In interlace mode no line is shortened.
- R7: `interlace_en` is sampled only on the edge that starts a new frame. A change made in mid-frame does not alter the current frame's line count or short line.
- R8: An edge with `latch_stb` high copies the dot and line counts, as they stood before that edge, into `hpos_q` and `vpos_q` together. With the strobe low, both outputs hold their values.
- R9: `vblank` is 1 exactly when the line count is at least `VBLANK_LINE` (240), through the last line of the frame.
- R10: `hblank` is 1 exactly when the dot count is at least `HBLANK_START` (274), or equals 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| interlace_en | input | 1 | Interlace request, applied at the next frame start |
| latch_stb | input | 1 | Capture strobe for the position holding registers |
| hpos_q | output | clog2(DOTS_PER_LINE) (9) | Latched dot count |
| vpos_q | output | clog2(LINES_PER_FIELD+1) (9) | Latched line count |
| vblank | output | 1 | Vertical blanking flag |
| hblank | output | 1 | Horizontal blanking flag |
| field | output | 1 | Field flag, inverts every frame |

## Verification
The bench uses a shrunken geometry: 12 dots, stretched dots 5 and 8, 10 lines, and short and blanking line 7. It latches on every edge and compares each cycle with a dot count derived arithmetically from the master-cycle offset within the line. This exposes the following faults:
- a stretched dot that is the wrong length or placed on the wrong dot, which shifts every later dot on the line;
- a short line on the wrong field or in interlace mode, which slips the whole following frame by four cycles;
- an extra line on the wrong field, which leaves the line count one step out of phase.

The bench also flips `interlace_en` in mid-frame to catch a design that samples it early. It holds the strobe low over stretches to catch latch registers that follow the counters.

// File: rtl/beam_pkg.sv
// Shared helpers for the beam position counter.
// Assumes: callers pass positive counts.
package beam_pkg;

    // Bits needed to hold values 0 .. n-1 (at least one bit).
    function automatic int cnt_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/beam_dot_divider.sv
// Divides master cycles into dots. A dot lasts MCYC_DOT cycles, or
// MCYC_LONG cycles while long_dot is high.
// Assumes: long_dot changes only on the edge after dot_end (it is
// decoded from the position counters, which move only then).
module beam_dot_divider #(
    parameter int MCYC_DOT  = 4,
    parameter int MCYC_LONG = 6,
    localparam int PW = beam_pkg::cnt_bits(MCYC_LONG)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic long_dot,
    output logic dot_end
);

    localparam logic [PW-1:0] LAST_NORM = PW'(MCYC_DOT - 1);
    localparam logic [PW-1:0] LAST_LONG = PW'(MCYC_LONG - 1);
    localparam logic [PW-1:0] NORM_LEN  = PW'(MCYC_DOT);
    localparam logic [PW-1:0] LONG_LEN  = PW'(MCYC_LONG);

    logic [PW-1:0] phase;
    logic [PW-1:0] phase_last;

    // Pick the final phase of the current dot from its kind.
    always_comb begin
        phase_last = long_dot ? LAST_LONG : LAST_NORM;
        dot_end    = (phase == phase_last);
    end

    // Master-cycle phase within the current dot.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (dot_end) phase <= '0;
        else              phase <= phase + 1'b1;
    end

    // R2
    norm_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !long_dot |-> phase < NORM_LEN)
        else $error("normal dot phase out of range");

    // R3
    long_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase < LONG_LEN)
        else $error("long dot phase out of range");

endmodule

// File: rtl/beam_raster_counter.sv
// Counts dots into lines and lines into frames. It keeps the field
// flag and the interlace mode in force for the current frame, and
// decodes which dots are stretched.
// Assumes: dot_end pulses for one cycle at the last master cycle of
// each dot; LONG_DOT_A < LONG_DOT_B < DOTS_PER_LINE.
module beam_raster_counter #(
    parameter int DOTS_PER_LINE   = 340,
    parameter int LONG_DOT_A      = 323,
    parameter int LONG_DOT_B      = 327,
    parameter int LINES_PER_FIELD = 262,
    parameter int SHORT_LINE      = 240,
    localparam int HW = beam_pkg::cnt_bits(DOTS_PER_LINE),
    localparam int VW = beam_pkg::cnt_bits(LINES_PER_FIELD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dot_end,
    input  logic          interlace_en,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic          field,
    output logic          long_dot
);

    localparam logic [HW-1:0] H_LAST   = HW'(DOTS_PER_LINE - 1);
    localparam logic [HW-1:0] H_LONG_A = HW'(LONG_DOT_A);
    localparam logic [HW-1:0] H_LONG_B = HW'(LONG_DOT_B);
    localparam logic [VW-1:0] V_LAST   = VW'(LINES_PER_FIELD - 1);
    localparam logic [VW-1:0] V_EXTRA  = VW'(LINES_PER_FIELD);
    localparam logic [VW-1:0] V_SHORT  = VW'(SHORT_LINE);

    logic          ilace_cur;
    logic          short_line;
    logic [VW-1:0] v_final;
    logic          line_end;
    logic          frame_end;

    // Decode per-frame geometry from the frame mode and field.
    always_comb begin
        short_line = !ilace_cur && field && (vcnt == V_SHORT);
        v_final    = (ilace_cur && field) ? V_EXTRA : V_LAST;
        long_dot   = !short_line && ((hcnt == H_LONG_A) || (hcnt == H_LONG_B));
        line_end   = dot_end && (hcnt == H_LAST);
        frame_end  = line_end && (vcnt == v_final);
    end

    // Dot counter: wraps at the end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n)        hcnt <= '0;
        else if (line_end) hcnt <= '0;
        else if (dot_end)  hcnt <= hcnt + 1'b1;
    end

    // Line counter: wraps at the end of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         vcnt <= '0;
        else if (frame_end) vcnt <= '0;
        else if (line_end)  vcnt <= vcnt + 1'b1;
    end

    // Field flag and frame interlace mode: both update at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field     <= 1'b0;
            ilace_cur <= 1'b0;
        end else if (frame_end) begin
            field     <= ~field;
            ilace_cur <= interlace_en;
        end
    end

    // R2
    h_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt <= H_LAST)
        else $error("dot count past line end");

    // R2
    v_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vcnt) |-> (hcnt == '0))
        else $error("line count moved away from dot 0");

    // R4
    field_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field) |-> (vcnt == '0 && hcnt == '0))
        else $error("field flag moved away from frame start");

    // R6
    v_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ilace_cur || !field) |-> (vcnt <= V_LAST))
        else $error("extra line outside odd interlaced frame");

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcnt != '0 || hcnt != '0) |-> $stable(ilace_cur))
        else $error("interlace mode changed in mid-frame");

endmodule

// File: rtl/beam_pos_latch.sv
// Holding registers that capture the dot and line counts together
// on a strobe.
// Assumes: the counts come straight from registers.
module beam_pos_latch #(
    parameter int HW = 9,
    parameter int VW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] vcnt,
    output logic [HW-1:0] hpos_q,
    output logic [VW-1:0] vpos_q
);

    // Capture both counts in the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos_q <= '0;
            vpos_q <= '0;
        end else if (stb) begin
            hpos_q <= hcnt;
            vpos_q <= vcnt;
        end
    end

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> ($stable(hpos_q) && $stable(vpos_q)))
        else $error("latched position changed without strobe");

endmodule

// File: rtl/beam_pos_counter.sv
// Top level of the beam position counter. It joins the dot divider,
// the raster counter and the position latch, and decodes the
// blanking flags from the live position.
// Assumes: VBLANK_LINE and SHORT_LINE lie below LINES_PER_FIELD and
// HBLANK_START lies below DOTS_PER_LINE.
module beam_pos_counter #(
    parameter int MCYC_DOT        = 4,
    parameter int MCYC_LONG       = 6,
    parameter int DOTS_PER_LINE   = 340,
    parameter int LONG_DOT_A      = 323,
    parameter int LONG_DOT_B      = 327,
    parameter int LINES_PER_FIELD = 262,
    parameter int SHORT_LINE      = 240,
    parameter int VBLANK_LINE     = 240,
    parameter int HBLANK_START    = 274,
    localparam int HW = beam_pkg::cnt_bits(DOTS_PER_LINE),
    localparam int VW = beam_pkg::cnt_bits(LINES_PER_FIELD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          interlace_en,
    input  logic          latch_stb,
    output logic [HW-1:0] hpos_q,
    output logic [VW-1:0] vpos_q,
    output logic          vblank,
    output logic          hblank,
    output logic          field
);

    localparam logic [HW-1:0] H_BLANK = HW'(HBLANK_START);
    localparam logic [VW-1:0] V_BLANK = VW'(VBLANK_LINE);

    logic          dot_end;
    logic          long_dot;
    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;

    beam_dot_divider #(
        .MCYC_DOT  (MCYC_DOT),
        .MCYC_LONG (MCYC_LONG)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .long_dot (long_dot),
        .dot_end  (dot_end)
    );

    beam_raster_counter #(
        .DOTS_PER_LINE   (DOTS_PER_LINE),
        .LONG_DOT_A      (LONG_DOT_A),
        .LONG_DOT_B      (LONG_DOT_B),
        .LINES_PER_FIELD (LINES_PER_FIELD),
        .SHORT_LINE      (SHORT_LINE)
    ) u_ras (
        .clk          (clk),
        .rst_n        (rst_n),
        .dot_end      (dot_end),
        .interlace_en (interlace_en),
        .hcnt         (hcnt),
        .vcnt         (vcnt),
        .field        (field),
        .long_dot     (long_dot)
    );

    beam_pos_latch #(
        .HW (HW),
        .VW (VW)
    ) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (latch_stb),
        .hcnt   (hcnt),
        .vcnt   (vcnt),
        .hpos_q (hpos_q),
        .vpos_q (vpos_q)
    );

    // Blanking flags decoded from the live position.
    always_comb begin
        vblank = (vcnt >= V_BLANK);
        hblank = (hcnt >= H_BLANK) || (hcnt == '0);
    end

    // R9
    vblank_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vblank) |-> (vcnt == V_BLANK && hcnt == '0))
        else $error("vblank rose away from its first line");

    // R10
    hblank_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hblank) |-> (hcnt == HW'(1)))
        else $error("hblank fell away from dot 1");

endmodule

// File: tb/beam_pos_counter_tb.sv
// Sweeps whole frames of a shrunken geometry and checks every cycle
// against a position computed from the master-cycle offset in the line.
module beam_pos_counter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int D   = 4;
    localparam int LG  = 6;
    localparam int NDOT = 12;
    localparam int LA  = 5;
    localparam int LB  = 8;
    localparam int NL  = 10;
    localparam int SL  = 7;
    localparam int VB  = 7;
    localparam int HB  = 9;
    localparam int HW  = beam_pkg::cnt_bits(NDOT);
    localparam int VW  = beam_pkg::cnt_bits(NL + 1);
    localparam int MAX_CYCLES = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          interlace_en = 1'b0;
    logic          latch_stb = 1'b0;
    logic [HW-1:0] hpos_q;
    logic [VW-1:0] vpos_q;
    logic          vblank;
    logic          hblank;
    logic          field;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference state: master cycle in line, line, field, frame mode.
    int m_mc = 0, m_line = 0, m_field = 0, m_il = 0;
    int lat_h = 0, lat_v = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    beam_pos_counter #(
        .MCYC_DOT(D), .MCYC_LONG(LG), .DOTS_PER_LINE(NDOT),
        .LONG_DOT_A(LA), .LONG_DOT_B(LB), .LINES_PER_FIELD(NL),
        .SHORT_LINE(SL), .VBLANK_LINE(VB), .HBLANK_START(HB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .interlace_en(interlace_en),
        .latch_stb(latch_stb), .hpos_q(hpos_q), .vpos_q(vpos_q),
        .vblank(vblank), .hblank(hblank), .field(field)
    );

    function automatic bit is_short(input int line, input int fld, input int il);
        return (il == 0) && (fld == 1) && (line == SL);
    endfunction

    function automatic int line_len(input bit shrt);
        return shrt ? NDOT * D : NDOT * D + 2 * (LG - D);
    endfunction

    // Dot index from the master-cycle offset in the line.
    function automatic int dot_at(input int mc, input bit shrt);
        if (shrt || mc < LA * D)        return mc / D;
        if (mc < LA * D + LG)           return LA;
        if (mc < LB * D + LG - D)       return LA + 1 + (mc - LA * D - LG) / D;
        if (mc < LB * D + 2 * LG - D)   return LB;
        return LB + 1 + (mc - LB * D - 2 * LG + D) / D;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mc = 0; m_line = 0; m_field = 0; m_il = 0;
        lat_h = 0; lat_v = 0;
    endtask

    // One master cycle: capture pre-edge position, advance, compare.
    task automatic step();
        bit shrt;
        int pre_h, pre_v, nl, h_now;
        string htag, vtag;
        @(posedge clk);
        shrt  = is_short(m_line, m_field, m_il);
        pre_h = dot_at(m_mc, shrt);
        pre_v = m_line;
        htag  = shrt ? "R5" : ((pre_h == LA || pre_h == LB || pre_h > LA) ? "R3" : "R2");
        vtag  = (interlace_en != m_il) ? "R7" : (m_il != 0 ? "R6" : "R4");
        if (latch_stb) begin
            lat_h = pre_h; lat_v = pre_v;
        end
        m_mc++;
        if (m_mc == line_len(shrt)) begin
            m_mc = 0;
            m_line++;
            nl = (m_il != 0 && m_field == 1) ? NL + 1 : NL;
            if (m_line == nl) begin
                m_line = 0;
                m_field ^= 1;
                m_il = interlace_en;
            end
        end
        @(negedge clk);
        if (!latch_stb) htag = "R8";
        check(htag, int'(hpos_q), lat_h);
        check(latch_stb ? vtag : "R8", int'(vpos_q), lat_v);
        check("R4 field", int'(field), m_field);
        check("R9", int'(vblank), int'(m_line >= VB));
        h_now = dot_at(m_mc, is_short(m_line, m_field, m_il));
        check("R10", int'(hblank), int'(h_now >= HB || h_now == 0));
    endtask

    task automatic reset_check();
        check("R1 hpos", int'(hpos_q), 0);
        check("R1 vpos", int'(vpos_q), 0);
        check("R1 field", int'(field), 0);
        check("R1 vblank", int'(vblank), 0);
        check("R10 reset", int'(hblank), 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int flen;
        flen = NL * line_len(1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        reset_check();                       // R1
        model_reset();
        rst_n = 1'b1;
        latch_stb = 1'b1;
        // R4 R5: non-interlaced frames, both fields.
        for (int i = 0; i < 4 * flen; i++) step();
        // R7: request interlace in mid-frame.
        for (int i = 0; i < 100; i++) step();
        interlace_en = 1'b1;
        // R6: interlaced frames, both fields.
        for (int i = 0; i < 5 * flen; i++) step();
        // R8: sparse strobes, registers hold in between.
        for (int i = 0; i < flen; i++) begin
            latch_stb = (i % 7 == 0);
            step();
        end
        latch_stb = 1'b1;
        // R7: drop interlace in mid-frame, then run on.
        for (int i = 0; i < 37; i++) step();
        interlace_en = 1'b0;
        for (int i = 0; i < 3 * flen; i++) step();
        // R1: reset in mid-run.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        reset_check();
        model_reset();
        rst_n = 1'b1;
        for (int i = 0; i < 2 * flen; i++) step();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule